// File: doc/BRIEF.md
# Component Video Chroma Decimator (4:4:4 to 4:2:2)

This block sits on a digitized video path and receives one pixel per clock on three parallel lanes of configurable width (10 bits by default). In component mode, the green lane carries luma, the blue lane carries Cb and the red lane carries Cr. In RGB mode, the lanes carry plain colour samples. The block performs no colour-space conversion. RGB input leaves as RGB, and component input leaves as YCbCr.

When component mode and decimation are both enabled, the block reduces the stream to 4:2:2 by dropping samples. Luma passes on every pixel. The red lane alternates between the Cb and Cr of each even pixel, and the blue lane is held at zero. The pixel phase restarts on every line-start marker. A single register stage delays the data, the valid strobe and the line-start marker by the same amount, so they stay aligned. On clocks with no valid pixel, the chroma lanes carry the black level of the current format.

Top module: `cv_decim422`

## Requirements
- R1: The green lane output equals the green input of the previous clock whenever that clock carried a valid pixel, in every mode.
- R2: With component mode and decimation enabled, the red lane output for a valid even pixel is that pixel's blue-lane input (Cb). For the following valid odd pixel, it is the red-lane input (Cr) captured from that even pixel. Both outputs appear with one clock of latency.
- R3: With component mode and decimation enabled, the blue lane output is all zeros on every clock.
- R4: With decimation disabled, the blue and red outputs equal the blue and red inputs of the previous valid clock (4:4:4).
- R5: In RGB mode (component mode low), the decimation enable has no effect, and the data passes as 4:4:4.
- R6: A clock with the line-start input high resets the phase, so a valid pixel on that clock or the first valid pixel after it is even. Clocks with valid low do not advance the phase.
- R7: After a clock with valid low, the green output is 0. In component mode, the chroma outputs are mid-scale (0x200 for 10 bits), except that the blue lane is 0 in 4:2:2. In RGB mode, all lanes are 0.
- R8: The valid and line-start outputs equal the corresponding inputs delayed by exactly one clock.
- R9: While reset is asserted, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| comp_mode_i | input | 1 | 1 = component (YCbCr) input, 0 = RGB |
| decim_en_i | input | 1 | 1 = produce 4:2:2 when in component mode |
| line_start_i | input | 1 | Line-start marker, resets pixel phase |
| valid_i | input | 1 | Pixel valid strobe |
| grn_i | input | DW | Green lane (luma) |
| blu_i | input | DW | Blue lane (Cb) |
| red_i | input | DW | Red lane (Cr) |
| valid_o | output | 1 | Delayed valid |
| line_start_o | output | 1 | Delayed line-start marker |
| grn_o | output | DW | Green lane output |
| blu_o | output | DW | Blue lane output |
| red_o | output | DW | Red lane output (alternating chroma in 4:2:2) |

## Verification
The hidden state here is the one-bit pixel phase and the held Cr sample. A wrong phase is visible one clock later: the red lane swaps Cb and Cr on the affected pixel, and the swap continues until the next line-start marker. A stale or mis-captured held sample shows up on the very next odd pixel as a red value that matches no Cr in the line. The sweep covers all four mode combinations, lines of odd and even length, line-start markers on both valid and idle clocks, and idle gaps inside a line. Each output is compared with arithmetically generated stimulus on every clock.

// File: rtl/cv_decim_pkg.sv
package cv_decim_pkg;
  typedef enum logic [1:0] {
    FMT_RGB444 = 2'd0,
    FMT_YC444  = 2'd1,
    FMT_YC422  = 2'd2
  } fmt_e;

  function automatic int unsigned mid_code(int unsigned dw);
    return 32'd1 << (dw - 1);
  endfunction
endpackage

// File: rtl/cv_decim_phase.sv
module cv_decim_phase (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_start_i,
  input  logic valid_i,
  output logic odd_o
);
  logic odd_q;

  assign odd_o = line_start_i ? 1'b0 : odd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      odd_q <= 1'b0;
    else if (valid_i) odd_q <= ~odd_o;
    else              odd_q <= odd_o;
  end
endmodule

// File: rtl/cv_decim_chroma.sv
module cv_decim_chroma
  import cv_decim_pkg::*;
#(
  parameter int unsigned DW = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  fmt_e          fmt_i,
  input  logic          valid_i,
  input  logic          odd_i,
  input  logic [DW-1:0] cb_i,
  input  logic [DW-1:0] cr_i,
  output logic [DW-1:0] blu_nx_o,
  output logic [DW-1:0] red_nx_o
);
  localparam logic [DW-1:0] MID = DW'(mid_code(DW));

  logic [DW-1:0] cr_hold_q;
  logic [DW-1:0] black;

  // Cr of the even pixel waits one pixel for the odd slot
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cr_hold_q <= '0;
    else if (valid_i && !odd_i && fmt_i == FMT_YC422) cr_hold_q <= cr_i;
  end

  assign black = (fmt_i == FMT_RGB444) ? '0 : MID;

  always_comb begin
    unique case (fmt_i)
      FMT_YC422: begin
        blu_nx_o = '0;
        if (!valid_i)   red_nx_o = MID;
        else if (odd_i) red_nx_o = cr_hold_q;
        else            red_nx_o = cb_i;
      end
      default: begin
        blu_nx_o = valid_i ? cb_i : black;
        red_nx_o = valid_i ? cr_i : black;
      end
    endcase
  end
endmodule

// File: rtl/cv_decim_oreg.sv
module cv_decim_oreg #(
  parameter int unsigned LANES = 3,
  parameter int unsigned DW    = 10
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [LANES-1:0][DW-1:0] d_i,
  output logic [LANES-1:0][DW-1:0] q_o
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q_o[l] <= '0;
      else         q_o[l] <= d_i[l];
    end
  end
endmodule

// File: rtl/cv_decim422.sv
module cv_decim422
  import cv_decim_pkg::*;
#(
  parameter int unsigned DW = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          comp_mode_i,
  input  logic          decim_en_i,
  input  logic          line_start_i,
  input  logic          valid_i,
  input  logic [DW-1:0] grn_i,
  input  logic [DW-1:0] blu_i,
  input  logic [DW-1:0] red_i,
  output logic          valid_o,
  output logic          line_start_o,
  output logic [DW-1:0] grn_o,
  output logic [DW-1:0] blu_o,
  output logic [DW-1:0] red_o
);
  localparam int unsigned NLANE = 3;

  fmt_e          fmt;
  logic          odd;
  logic [DW-1:0] blu_nx;
  logic [DW-1:0] red_nx;
  logic [NLANE-1:0][DW-1:0] lane_d;
  logic [NLANE-1:0][DW-1:0] lane_q;
  logic [1:0]    ctl_q;

  // decimation only meaningful for component input
  assign fmt = !comp_mode_i ? FMT_RGB444 : (decim_en_i ? FMT_YC422 : FMT_YC444);

  cv_decim_phase u_phase (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .line_start_i (line_start_i),
    .valid_i      (valid_i),
    .odd_o        (odd)
  );

  cv_decim_chroma #(.DW(DW)) u_chroma (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .fmt_i    (fmt),
    .valid_i  (valid_i),
    .odd_i    (odd),
    .cb_i     (blu_i),
    .cr_i     (red_i),
    .blu_nx_o (blu_nx),
    .red_nx_o (red_nx)
  );

  assign lane_d[0] = valid_i ? grn_i : '0;
  assign lane_d[1] = blu_nx;
  assign lane_d[2] = red_nx;

  cv_decim_oreg #(.LANES(NLANE), .DW(DW)) u_oreg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (lane_d),
    .q_o    (lane_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctl_q <= '0;
    else         ctl_q <= {line_start_i, valid_i};
  end

  assign grn_o        = lane_q[0];
  assign blu_o        = lane_q[1];
  assign red_o        = lane_q[2];
  assign valid_o      = ctl_q[0];
  assign line_start_o = ctl_q[1];
endmodule

// File: rtl/cv_decim422_chk.sv
module cv_decim422_chk #(
  parameter int unsigned DW = 10
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          comp_mode_i,
  input logic          decim_en_i,
  input logic          line_start_i,
  input logic          valid_i,
  input logic [DW-1:0] grn_i,
  input logic [DW-1:0] blu_i,
  input logic [DW-1:0] red_i,
  input logic          valid_o,
  input logic          line_start_o,
  input logic [DW-1:0] grn_o,
  input logic [DW-1:0] blu_o,
  input logic [DW-1:0] red_o
);
  logic armed_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed_q <= 1'b0;
    else         armed_q <= 1'b1;
  end

  AST_LUMA_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q && $past(valid_i) |-> grn_o == $past(grn_i)); // R1

  AST_FIRST_IS_CB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q && $past(valid_i && line_start_i && comp_mode_i && decim_en_i)
    |-> red_o == $past(blu_i)); // R2

  AST_BLUE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q && $past(comp_mode_i && decim_en_i) |-> blu_o == '0); // R3

  AST_FULL_CHROMA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q && $past(valid_i && !(comp_mode_i && decim_en_i))
    |-> blu_o == $past(blu_i) && red_o == $past(red_i)); // R4

  AST_IDLE_LUMA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q && $past(!valid_i) |-> grn_o == '0); // R7

  AST_CTL_DELAY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q |-> valid_o == $past(valid_i) && line_start_o == $past(line_start_i)); // R8

  always_comb begin
    if (!rst_ni) begin
      AST_RESET_QUIET: assert (!valid_o && !line_start_o && grn_o == '0 &&
                               blu_o == '0 && red_o == '0); // R9
    end
  end
endmodule

bind cv_decim422 cv_decim422_chk #(.DW(DW)) u_chk (.*);

// File: tb/cv_decim422_bench.sv
`timescale 1ns/1ps
module cv_decim422_bench;
  localparam int unsigned DW  = 10;
  localparam logic [DW-1:0] MID = 10'h200;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          comp_mode_i = 1'b0;
  logic          decim_en_i = 1'b0;
  logic          line_start_i = 1'b0;
  logic          valid_i = 1'b0;
  logic [DW-1:0] grn_i = '0;
  logic [DW-1:0] blu_i = '0;
  logic [DW-1:0] red_i = '0;
  logic          valid_o;
  logic          line_start_o;
  logic [DW-1:0] grn_o;
  logic [DW-1:0] blu_o;
  logic [DW-1:0] red_o;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  logic          m_odd;
  logic [DW-1:0] m_hold;

  always #2 clk = ~clk;

  cv_decim422 #(.DW(DW)) u_cv_decim422 (
    .clk_i(clk), .rst_ni(rst_ni), .comp_mode_i(comp_mode_i), .decim_en_i(decim_en_i),
    .line_start_i(line_start_i), .valid_i(valid_i), .grn_i(grn_i), .blu_i(blu_i),
    .red_i(red_i), .valid_o(valid_o), .line_start_o(line_start_o), .grn_o(grn_o),
    .blu_o(blu_o), .red_o(red_o)
  );

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic step(bit ls, bit v, logic [DW-1:0] g, logic [DW-1:0] b, logic [DW-1:0] r);
    bit dec;
    bit ph;
    logic [DW-1:0] eg, eb, er;
    string rq;
    dec = comp_mode_i && decim_en_i;
    ph  = ls ? 1'b0 : m_odd;
    eg  = v ? g : '0;
    if (dec) begin
      eb = '0;
      er = !v ? MID : (ph ? m_hold : b);
      rq = (ls && v) ? "R6" : (v ? "R2" : "R7");
    end else begin
      eb = v ? b : (comp_mode_i ? MID : '0);
      er = v ? r : (comp_mode_i ? MID : '0);
      rq = !v ? "R7" : (!comp_mode_i && decim_en_i) ? "R5" : "R4";
    end
    @(negedge clk);
    line_start_i = ls; valid_i = v; grn_i = g; blu_i = b; red_i = r;
    @(posedge clk);
    #1;
    chk(v ? "R1" : "R7", "green", int'(grn_o), int'(eg));
    chk(dec ? "R3" : rq, "blue", int'(blu_o), int'(eb));
    chk(rq, "red", int'(red_o), int'(er));
    chk("R8", "valid", int'(valid_o), int'(v));
    chk("R8", "line_start", int'(line_start_o), int'(ls));
    if (v && dec && !ph) m_hold = r;
    m_odd = v ? ~ph : ph;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    m_odd = 1'b0;
    m_hold = '0;
    repeat (3) @(posedge clk);
    #1;
    chk("R9", "valid in reset", int'(valid_o), 0);
    chk("R9", "line_start in reset", int'(line_start_o), 0);
    chk("R9", "lanes in reset", int'(grn_o | blu_o | red_o), 0);
    @(negedge clk);
    rst_ni = 1'b1;
    for (int mode = 0; mode < 4; mode++) begin
      @(negedge clk);
      comp_mode_i = mode[1];
      decim_en_i  = mode[0];
      step(1'b0, 1'b0, '0, '0, '0);
      for (int ln = 0; ln < 4; ln++) begin
        int npix;
        npix = 5 + ln;
        if (ln == 2) step(1'b1, 1'b0, '0, '0, '0); // marker on idle clock
        for (int px = 0; px < npix; px++) begin
          logic [DW-1:0] g, b, r;
          g = DW'(ln * 97 + px * 13 + mode * 7 + 1);
          b = DW'(ln * 61 + px * 29 + mode * 3 + 400);
          r = DW'(ln * 43 + px * 71 + mode * 11 + 700);
          if (px == 2 && ln[0]) step(1'b0, 1'b0, '0, '0, '0); // gap mid-line
          step((px == 0) && (ln != 2), 1'b1, g, b, r);
        end
        step(1'b0, 1'b0, '0, '0, '0);
      end
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule